// File: doc/BRIEF.md
# Nixie Cathode Frame Serializer

This block turns four 4-bit digit codes into the cathode pattern for four nixie tubes and sends that pattern over a two-wire serial link (clock and data) into a chain of five 8-bit shift registers. When the 40th bit has been sent, it pulses a latch line so that every register output changes at the same moment. It also holds one power-enable output for each tube.

The tubes sit at positions A, B, D and E. Each tube owns a 10-bit group of the 40-bit frame. A caller places the four codes on `digits_i` and raises `start_i` for one cycle while `busy_o` is low. The block registers the frame and the power enables in that cycle. It then shifts the frame out, latches it, and reports completion with a one-cycle `done_o`.

Code 0xF blanks a tube: the tube's group is all zeros and its power enable turns off. Codes 10 to 14 are displayed as digit 0.

Top module: `nixie_frame_tx`

## Requirements
- R1: After reset, `sdata_o`, `sclk_o`, `latch_o`, `busy_o`, `done_o` and all bits of `pwr_en_o` are low.
- R2: For a digit d from 1 to 9, the tube's group has exactly one bit set, at group offset d-1, and the other nine bits of the group are zero.
- R3: Digit 0 sets only offset 9, the top bit of the tube's group.
- R4: Codes 10 to 14 produce the same group as digit 0.
- R5: Code 0xF leaves the tube's whole group zero and clears that tube's `pwr_en_o` bit. Any other code sets that bit. Bit t of `pwr_en_o` belongs to the tube whose code is `digits_i[4t+3:4t]`.
- R6: Tube A (`digits_i[3:0]`) occupies frame bits 9..0, B (`[7:4]`) bits 19..10, D (`[11:8]`) bits 29..20 and E (`[15:12]`) bits 39..30. The frame is sent bit 39 first and bit 0 last, which is five bytes each sent MSB first.
- R7: `sclk_o` idles low. Each serial bit lasts 16 system clocks: 8 clocks low, then 8 clocks high. `sdata_o` changes only while `sclk_o` is low, so it is stable across each rising edge.
- R8: After the 40th bit, `latch_o` is high for exactly 16 system clocks. `sclk_o` stays low during that time.
- R9: `busy_o` goes high in the cycle after an accepted start. In the cycle after `latch_o` falls, `busy_o` is low and `done_o` is high for exactly one cycle.
- R10: A `start_i` pulse while `busy_o` is high is ignored. The power enables do not change and no extra frame is sent.
- R11: `pwr_en_o` changes only when a start is accepted, and then holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to load and send a frame |
| digits_i | input | 16 | Four digit codes: A in [3:0], B in [7:4], D in [11:8], E in [15:12] |
| busy_o | output | 1 | High while a frame is being shifted or latched |
| done_o | output | 1 | One-cycle pulse after the latch pulse ends |
| sclk_o | output | 1 | Serial clock, system clock divided by 16, idles low |
| sdata_o | output | 1 | Serial data, sampled by the shift registers on the rising edge of `sclk_o` |
| latch_o | output | 1 | Transfers the shifted frame to the shift-register outputs |
| pwr_en_o | output | 4 | Per-tube power enable, registered at start |

## Verification
The assertions assume `start_i` is a clean synchronous level after reset. A start raised while busy is assumed to have no effect on the outputs. The stimulus drives `start_i` and `digits_i` only on the falling clock edge and holds a normal start for a single cycle. On purpose, it raises one start in the middle of a transfer, so that the ignore rule is exercised rather than assumed. The digit values are held while a start is sampled. Between frames they may change freely, because the design registers everything it needs when the start is accepted.

// File: rtl/nixie_pkg.sv
package nixie_pkg;
  typedef enum logic [1:0] {
    SER_IDLE  = 2'd0,
    SER_SHIFT = 2'd1,
    SER_LATCH = 2'd2
  } ser_state_t;
endpackage

// File: rtl/nixie_tube_enc.sv
module nixie_tube_enc #(
  parameter int CODE_W  = 4,
  parameter int GROUP_W = 10
) (
  input  logic [CODE_W-1:0]  code_i,
  output logic [GROUP_W-1:0] group_o,
  output logic               pwr_o
);
  localparam logic [CODE_W-1:0] BLANK = {CODE_W{1'b1}};
  localparam int                ZERO_POS = GROUP_W - 1;

  // fold out-of-range codes onto digit zero; blank passes through
  function automatic logic [CODE_W-1:0] clean_code(input logic [CODE_W-1:0] c);
    if (c == BLANK)                     return c;
    if (int'(c) > GROUP_W - 1)          return '0;
    return c;
  endfunction

  // one cathode per digit: zero lives in the top slot, d in slot d-1
  function automatic logic [GROUP_W-1:0] cathode_of(input logic [CODE_W-1:0] c);
    logic [GROUP_W-1:0] g;
    g = '0;
    if (c == BLANK)   g = '0;
    else if (c == '0) g[ZERO_POS] = 1'b1;
    else              g[int'(c) - 1] = 1'b1;
    return g;
  endfunction

  logic [CODE_W-1:0] code_clean;

  always_comb begin
    code_clean = clean_code(code_i);
    group_o    = cathode_of(code_clean);
    pwr_o      = (code_i != BLANK);
  end
endmodule

// File: rtl/nixie_frame_build.sv
module nixie_frame_build #(
  parameter int NUM_TUBES = 4,
  parameter int CODE_W    = 4,
  parameter int GROUP_W   = 10
) (
  input  logic [NUM_TUBES*CODE_W-1:0]  digits_i,
  output logic [NUM_TUBES*GROUP_W-1:0] frame_o,
  output logic [NUM_TUBES-1:0]         pwr_o
);
  for (genvar t = 0; t < NUM_TUBES; t++) begin : g_tube
    nixie_tube_enc #(
      .CODE_W (CODE_W),
      .GROUP_W(GROUP_W)
    ) u_enc (
      .code_i (digits_i[t*CODE_W +: CODE_W]),
      .group_o(frame_o[t*GROUP_W +: GROUP_W]),
      .pwr_o  (pwr_o[t])
    );
  end
endmodule

// File: rtl/nixie_serial_out.sv
module nixie_serial_out
  import nixie_pkg::*;
#(
  parameter int FRAME_W = 40,
  parameter int CLK_DIV = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               sclk_o,
  output logic               sdata_o,
  output logic               latch_o
);
  localparam int DIV_W = $clog2(CLK_DIV);
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(CLK_DIV / 2);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

  ser_state_t         state;
  logic [DIV_W-1:0]   div_cnt;
  logic [BIT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] shreg;
  logic               done_q;

  // named events for the assertions
  logic slot_end;
  logic frame_end;
  assign slot_end  = (div_cnt == DIV_LAST);
  assign frame_end = (state == SER_SHIFT) && slot_end && (bit_cnt == BIT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SER_IDLE;
      div_cnt <= '0;
      bit_cnt <= '0;
      shreg   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        SER_IDLE: begin
          if (load_i) begin
            shreg   <= frame_i;
            bit_cnt <= '0;
            div_cnt <= '0;
            state   <= SER_SHIFT;
          end
        end
        SER_SHIFT: begin
          div_cnt <= slot_end ? '0 : div_cnt + DIV_W'(1);
          if (slot_end) begin
            if (bit_cnt == BIT_LAST) begin
              state <= SER_LATCH;
            end else begin
              shreg   <= {shreg[FRAME_W-2:0], 1'b0};
              bit_cnt <= bit_cnt + BIT_W'(1);
            end
          end
        end
        SER_LATCH: begin
          div_cnt <= slot_end ? '0 : div_cnt + DIV_W'(1);
          if (slot_end) begin
            state  <= SER_IDLE;
            done_q <= 1'b1;
          end
        end
        default: state <= SER_IDLE;
      endcase
    end
  end

  assign busy_o  = (state != SER_IDLE);
  assign done_o  = done_q;
  assign sclk_o  = (state == SER_SHIFT) && (div_cnt >= DIV_HALF);
  assign sdata_o = shreg[FRAME_W-1];
  assign latch_o = (state == SER_LATCH);

  // data holds across the whole high phase of the serial clock
  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

  // idle means clock low and latch low
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!sclk_o && !latch_o));

  // the latch follows the last bit immediately and never overlaps clocking
  p_latch_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> latch_o);
  p_latch_no_clock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |-> !sclk_o);
endmodule

// File: rtl/nixie_frame_tx.sv
module nixie_frame_tx #(
  parameter int NUM_TUBES = 4,
  parameter int CODE_W    = 4,
  parameter int GROUP_W   = 10,
  parameter int CLK_DIV   = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [NUM_TUBES*CODE_W-1:0] digits_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic                        sclk_o,
  output logic                        sdata_o,
  output logic                        latch_o,
  output logic [NUM_TUBES-1:0]        pwr_en_o
);
  localparam int FRAME_W = NUM_TUBES * GROUP_W;

  logic [FRAME_W-1:0]   frame_next;
  logic [NUM_TUBES-1:0] pwr_next;
  logic [NUM_TUBES-1:0] pwr_q;
  logic                 start_accept;

  nixie_frame_build #(
    .NUM_TUBES(NUM_TUBES),
    .CODE_W   (CODE_W),
    .GROUP_W  (GROUP_W)
  ) u_build (
    .digits_i(digits_i),
    .frame_o (frame_next),
    .pwr_o   (pwr_next)
  );

  assign start_accept = start_i && !busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pwr_q <= '0;
    else if (start_accept) pwr_q <= pwr_next;
  end

  assign pwr_en_o = pwr_q;

  nixie_serial_out #(
    .FRAME_W(FRAME_W),
    .CLK_DIV(CLK_DIV)
  ) u_ser (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start_accept),
    .frame_i(frame_next),
    .busy_o (busy_o),
    .done_o (done_o),
    .sclk_o (sclk_o),
    .sdata_o(sdata_o),
    .latch_o(latch_o)
  );

  p_busy_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> busy_o);
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> ($stable(pwr_en_o) && busy_o));
  p_pwr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !start_accept |=> $stable(pwr_en_o));
endmodule

// File: tb/test_nixie_frame_tx.sv
module test_nixie_frame_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] digits_i = '0;
  logic        busy_o, done_o, sclk_o, sdata_o, latch_o;
  logic [3:0]  pwr_en_o;

  int n_run = 0;
  int n_fail = 0;
  int frames_sent = 0;
  int frames_seen = 0;

  logic [39:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  nixie_frame_tx i_nixie_frame_tx (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .digits_i(digits_i),
    .busy_o(busy_o), .done_o(done_o), .sclk_o(sclk_o), .sdata_o(sdata_o),
    .latch_o(latch_o), .pwr_en_o(pwr_en_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference: restated from the requirements as a slot lookup
  function automatic logic [39:0] ref_frame(input logic [15:0] d);
    logic [39:0] f;
    f = '0;
    for (int t = 0; t < 4; t++) begin
      logic [3:0] c;
      int slot;
      c = d[t*4 +: 4];
      case (c)
        4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9: slot = int'(c) - 1;
        4'hF:    slot = -1;
        default: slot = 9;
      endcase
      if (slot >= 0) f[t*10 + slot] = 1'b1;
    end
    return f;
  endfunction

  function automatic logic [3:0] ref_pwr(input logic [15:0] d);
    logic [3:0] p;
    for (int t = 0; t < 4; t++) p[t] = (d[t*4 +: 4] != 4'hF);
    return p;
  endfunction

  // driver: push expectation, issue start, check handshake and power
  task automatic send(input logic [15:0] d, input string tag);
    while (busy_o) @(negedge clk);
    exp_q.push_back(ref_frame(d));
    tag_q.push_back(tag);
    frames_sent++;
    digits_i = d;
    start_i  = 1'b1;
    @(negedge clk);
    start_i  = 1'b0;
    check(busy_o == 1'b1, "R9 busy after start", 64'(busy_o), 64'd1);
    check(pwr_en_o == ref_pwr(d), {"R5/R11 power ", tag}, 64'(pwr_en_o), 64'(ref_pwr(d)));
  endtask

  // monitor
  logic        sclk_prev = 1'b0, latch_prev = 1'b0, done_prev = 1'b0;
  logic [39:0] got = '0;
  int          nbits = 0, bad_gap = 0, latch_len = 0;
  longint      cyc = 0, last_rise = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk_o && !sclk_prev) begin
        if (nbits > 0 && (cyc - last_rise) != 16) bad_gap++;
        last_rise = cyc;
        got = {got[38:0], sdata_o};
        nbits++;
      end
      if (latch_o) begin
        if (sclk_o) bad_gap++;
        latch_len++;
      end
      if (latch_o && !latch_prev) begin
        frames_seen++;
        check(nbits == 40, "R6 bit count", 64'(nbits), 64'd40);
        check(bad_gap == 0, "R7 serial clock period", 64'(bad_gap), 64'd0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected frame", {24'd0, got}, 64'd0);
        end else begin
          logic [39:0] e;
          string tg;
          e  = exp_q.pop_front();
          tg = tag_q.pop_front();
          check(got == e, {"R6 frame ", tg}, {24'd0, got}, {24'd0, e});
        end
        nbits = 0;
        bad_gap = 0;
      end
      if (!latch_o && latch_prev) begin
        check(latch_len == 16, "R8 latch width", 64'(latch_len), 64'd16);
        latch_len = 0;
      end
      if (done_o) begin
        check(latch_prev && !latch_o && !busy_o, "R9 done timing",
              {61'd0, latch_prev, latch_o, busy_o}, 64'b100);
      end
      if (done_prev) check(!done_o, "R9 done width", 64'(done_o), 64'd0);
      sclk_prev  = sclk_o;
      latch_prev = latch_o;
      done_prev  = done_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({sdata_o, sclk_o, latch_o, busy_o, done_o, pwr_en_o} == '0,
          "R1 reset outputs", {sdata_o, sclk_o, latch_o, busy_o, done_o, pwr_en_o}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({sdata_o, sclk_o, latch_o, busy_o, pwr_en_o} == '0,
          "R1 idle after reset", {sdata_o, sclk_o, latch_o, busy_o, pwr_en_o}, 64'd0);

    send(16'h4321, "R2 digits 1-4");
    send(16'h9876, "R2 digits 6-9");
    send(16'h0505, "R3 zeros mixed");
    send(16'h0000, "R3 all zero");
    send(16'hDCBA, "R4 codes 10-13");
    send(16'h1E2E, "R4 code 14");
    send(16'hF0F5, "R5 blanks mixed");
    send(16'hFFFF, "R5 all blank");

    // R10: a start while busy must be ignored
    send(16'h1357, "R10 first frame");
    repeat (100) @(negedge clk);
    digits_i = 16'hFFFF;
    start_i  = 1'b1;
    @(negedge clk);
    start_i  = 1'b0;
    check(pwr_en_o == 4'hF, "R10 power unchanged", 64'(pwr_en_o), 64'hF);
    while (busy_o) @(negedge clk);
    repeat (800) @(negedge clk);
    check(frames_seen == frames_sent, "R10 frame count", 64'(frames_seen), 64'(frames_sent));
    check(pwr_en_o == 4'hF, "R11 power held", 64'(pwr_en_o), 64'hF);
    check(!sclk_o && !latch_o, "R7 idle low", {62'd0, sclk_o, latch_o}, 64'd0);

    send(16'h8F0C, "R6 final mix");
    while (busy_o) @(negedge clk);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R6 queue drained", 64'(exp_q.size()), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule